// File: doc/BRIEF.md
# Dual-Edge DAC Sample Formatter

This block sits just ahead of a four-switch DAC core that converts one sample on the rising edge of its clock and another on the falling edge. It takes one signed sample per clock and emits a registered pair per clock: a rising-edge slot and a falling-edge slot. The rising-edge slot always carries the data sample. What goes into the falling-edge slot depends on a two-bit mode.

- **Hold:** the sample is repeated, as in plain non-return-to-zero output.
- **Mix:** the sample is negated, so the converter clock acts as a local oscillator.
- **Return to zero:** the slot is zero.
- **Doubled rate:** the slot takes an interpolated sample from an external filter, which doubles the effective update rate.

In doubled-rate mode the data sample passes through a delay line whose length matches the filter's latency. This keeps each data sample aligned with the interpolated sample computed after it. The delay line shifts every cycle in every mode, so its contents are always current when the mode switches. The mode is registered together with each pair, so a pair is never formed under two modes.

Top module: `dual_edge_fmt`

## Requirements
- R1: Outside doubled-rate mode, the rising-edge slot `rise_o` one clock after an input cycle equals that cycle's `smp_i` when `smp_vld_i` was high.
- R2: In hold mode (`mode_i` = 2'b00), the falling-edge slot equals the rising-edge slot.
- R3: In mix mode (`mode_i` = 2'b01), the falling-edge slot is the two's-complement negation of the rising-edge slot.
- R4: The negation in mix mode saturates: a rising-edge value of the most negative code (16'h8000 at default width) gives the most positive code (16'h7FFF) in the falling-edge slot.
- R5: In return-to-zero mode (`mode_i` = 2'b10), the falling-edge slot is zero.
- R6: In doubled-rate mode (`mode_i` = 2'b11), the falling-edge slot one clock after an input cycle is that cycle's `interp_i`. The rising-edge slot is the `smp_i` seen `FILT_LAT` cycles earlier, and its validity is the `smp_vld_i` from that same earlier cycle.
- R7: When the selected sample is not valid, `vld_o` is low and both slots are zero, whatever the mode.
- R8: Each output pair is built entirely under the mode presented in its own input cycle, including when the mode changes on every cycle.
- R9: While `rst_n` is low, and in the first cycle after it is released, both slots and `vld_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | DW | Signed input sample |
| smp_vld_i | input | 1 | Input sample valid |
| mode_i | input | 2 | Falling-slot mode: 00 hold, 01 mix, 10 return to zero, 11 doubled rate |
| interp_i | input | DW | Signed interpolated sample from the external filter |
| rise_o | output | DW | Registered rising-edge slot sample |
| fall_o | output | DW | Registered falling-edge slot sample |
| vld_o | output | 1 | Output pair valid |

## Verification
Two functions can meet in one cycle.

- **Doubled-rate entry:** a switch into doubled-rate mode coincides with the delay line releasing a sample taken under an earlier mode. The rising slot must then show that old sample and its old validity, while the falling slot shows this cycle's filter input.
- **Saturating negation:** in mix mode the most negative code is fed together with a valid toggle on the same edge.

Directed bursts provoke both cases by switching mode every cycle and placing extreme codes next to invalid cycles. A seeded random phase mixes modes, validity and extreme values. Each output pair is judged against a bench model that keeps its own history of every driven input and applies the requirement for the mode recorded with that input.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_MIX  = 2'b01,
    MODE_RTZ  = 2'b10,
    MODE_DBL  = 2'b11
  } fmt_mode_e;

  // Saturating two's-complement negation for a sample of width w.
  function automatic logic [31:0] sat_neg(input logic [31:0] x, input int w);
    logic [31:0] mask;
    logic [31:0] minv;
    logic [31:0] res;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    minv = 32'h1 << (w - 1);
    if ((x & mask) == minv) res = minv - 32'h1;
    else                    res = (~x + 32'h1) & mask;
    return res;
  endfunction

endpackage

// File: rtl/fmt_delay_line.sv
module fmt_delay_line #(
  parameter int DW  = 16,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d_i,
  input  logic          v_i,
  output logic [DW-1:0] d_o,
  output logic          v_o
);

  generate
    if (LAT == 0) begin : g_pass
      assign d_o = d_i;
      assign v_o = v_i;
    end else begin : g_pipe
      logic [DW-1:0] dat_q [LAT];
      logic [DW-1:0] dat_d [LAT];
      logic          val_q [LAT];
      logic          val_d [LAT];

      always_comb begin
        dat_d[0] = d_i;
        val_d[0] = v_i;
        for (int i = 1; i < LAT; i++) begin
          dat_d[i] = dat_q[i-1];
          val_d[i] = val_q[i-1];
        end
      end

      for (genvar g = 0; g < LAT; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            dat_q[g] <= '0;
            val_q[g] <= 1'b0;
          end else begin
            dat_q[g] <= dat_d[g];
            val_q[g] <= val_d[g];
          end
        end
      end

      assign d_o = dat_q[LAT-1];
      assign v_o = val_q[LAT-1];
    end
  endgenerate

endmodule

// File: rtl/fmt_slot_mux.sv
module fmt_slot_mux
  import fmt_pkg::*;
#(
  parameter int DW = 16
) (
  input  fmt_mode_e     mode_i,
  input  logic          vld_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] interp_i,
  output logic [DW-1:0] rise_o,
  output logic [DW-1:0] fall_o
);

  logic [31:0] neg_w;
  logic [DW-1:0] fall_raw;

  always_comb begin
    neg_w = sat_neg(32'(smp_i), DW);
    unique case (mode_i)
      MODE_HOLD: fall_raw = smp_i;
      MODE_MIX:  fall_raw = neg_w[DW-1:0];
      MODE_RTZ:  fall_raw = '0;
      MODE_DBL:  fall_raw = interp_i;
      default:   fall_raw = '0;
    endcase
    rise_o = vld_i ? smp_i    : '0;
    fall_o = vld_i ? fall_raw : '0;
  end

endmodule

// File: rtl/dual_edge_fmt.sv
module dual_edge_fmt
  import fmt_pkg::*;
#(
  parameter int DW       = 16,
  parameter int FILT_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] smp_i,
  input  logic          smp_vld_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] interp_i,
  output logic [DW-1:0] rise_o,
  output logic [DW-1:0] fall_o,
  output logic          vld_o
);

  localparam logic [DW-1:0] CODE_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] CODE_MAX = {1'b0, {(DW-1){1'b1}}};

  fmt_mode_e     mode_w;
  logic [DW-1:0] dly_smp;
  logic          dly_vld;
  logic [DW-1:0] sel_smp;
  logic          sel_vld;
  logic [DW-1:0] rise_d, fall_d;
  fmt_mode_e     mode_q;

  assign mode_w = fmt_mode_e'(mode_i);

  fmt_delay_line #(.DW(DW), .LAT(FILT_LAT)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (smp_i),
    .v_i   (smp_vld_i),
    .d_o   (dly_smp),
    .v_o   (dly_vld)
  );

  always_comb begin
    if (mode_w == MODE_DBL) begin
      sel_smp = dly_smp;
      sel_vld = dly_vld;
    end else begin
      sel_smp = smp_i;
      sel_vld = smp_vld_i;
    end
  end

  fmt_slot_mux #(.DW(DW)) u_mux (
    .mode_i   (mode_w),
    .vld_i    (sel_vld),
    .smp_i    (sel_smp),
    .interp_i (interp_i),
    .rise_o   (rise_d),
    .fall_o   (fall_d)
  );

  // Pair and its mode are captured on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_o <= '0;
      fall_o <= '0;
      vld_o  <= 1'b0;
      mode_q <= MODE_HOLD;
    end else begin
      rise_o <= rise_d;
      fall_o <= fall_d;
      vld_o  <= sel_vld;
      mode_q <= mode_w;
    end
  end

  assert_hold_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HOLD) |-> (fall_o == rise_o));

  assert_mix_negate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_MIX && rise_o != CODE_MIN) |-> (fall_o == DW'(-rise_o)));

  assert_mix_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_MIX && vld_o && rise_o == CODE_MIN) |-> (fall_o == CODE_MAX));

  assert_rtz_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RTZ) |-> (fall_o == '0));

  assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> (rise_o == '0 && fall_o == '0));

  assert_rise_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'(MODE_DBL)) |=>
      (rise_o == ($past(smp_vld_i) ? $past(smp_i) : '0)) && (vld_o == $past(smp_vld_i)));

  assert_dbl_interp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'(MODE_DBL)) |=> (fall_o == (vld_o ? $past(interp_i) : '0)));

  assert_mode_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mode_q == fmt_mode_e'($past(mode_i))));

endmodule

// File: tb/sim_dual_edge_fmt.sv
`timescale 1ns/1ps
module sim_dual_edge_fmt;

  localparam int DW  = 16;
  localparam int LAT = 3;
  localparam int N   = 3000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] smp_i;
  logic          smp_vld_i;
  logic [1:0]    mode_i;
  logic [DW-1:0] interp_i;
  logic [DW-1:0] rise_o, fall_o;
  logic          vld_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [DW-1:0] h_d [0:N-1];
  logic          h_v [0:N-1];
  logic [1:0]    h_m [0:N-1];
  logic [DW-1:0] h_i [0:N-1];
  bit            h_sw [0:N-1];

  always #4 clk = ~clk;

  dual_edge_fmt #(.DW(DW), .FILT_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .mode_i(mode_i), .interp_i(interp_i),
    .rise_o(rise_o), .fall_o(fall_o), .vld_o(vld_o)
  );

  function automatic logic [DW-1:0] neg_sat(logic [DW-1:0] x);
    if (x == 16'h8000) return 16'h7FFF;
    return 16'(-x);
  endfunction

  task automatic chk(string req, logic [DW-1:0] gr, logic [DW-1:0] gf, logic gv,
                     logic [DW-1:0] er, logic [DW-1:0] ef, logic ev);
    n_tests++;
    if (gr !== er || gf !== ef || gv !== ev) begin
      n_fail++;
      $display("FAIL %s: got rise=%h fall=%h vld=%b, expected rise=%h fall=%h vld=%b",
               req, gr, gf, gv, er, ef, ev);
    end
  endtask

  // Expected pair for input cycle k, from the requirements.
  task automatic check_cycle(int k);
    logic [DW-1:0] d, er, ef;
    logic v;
    string tag;
    if (h_m[k] == 2'b11) begin
      if (k - LAT >= 0) begin d = h_d[k-LAT]; v = h_v[k-LAT]; end
      else begin d = '0; v = 1'b0; end
    end else begin
      d = h_d[k]; v = h_v[k];
    end
    er = v ? d : '0;
    case (h_m[k])
      2'b00: begin ef = d;          tag = "R1,R2"; end
      2'b01: begin ef = neg_sat(d); tag = (d == 16'h8000) ? "R4" : "R1,R3"; end
      2'b10: begin ef = '0;         tag = "R1,R5"; end
      default: begin ef = h_i[k];   tag = "R6"; end
    endcase
    if (!v) begin ef = '0; tag = "R7"; end
    if (h_sw[k]) tag = {tag, ",R8"};
    chk(tag, rise_o, fall_o, vld_o, er, ef, v);
  endtask

  task automatic drive(int k, logic [DW-1:0] d, logic v, logic [1:0] m,
                       logic [DW-1:0] ip, bit sw);
    h_d[k] = d; h_v[k] = v; h_m[k] = m; h_i[k] = ip; h_sw[k] = sw;
    smp_i = d; smp_vld_i = v; mode_i = m; interp_i = ip;
  endtask

  function automatic logic [DW-1:0] rnd_smp();
    int r = $urandom_range(0, 9);
    if (r == 0) return 16'h8000;
    if (r == 1) return 16'h7FFF;
    if (r == 2) return 16'h8001;
    return 16'($urandom);
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    smp_i = 16'h1234; smp_vld_i = 1'b1; mode_i = 2'b01; interp_i = 16'h4321;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", rise_o, fall_o, vld_o, '0, '0, 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) begin
      if (k > 0) check_cycle(k - 1);
      if (k < 8)
        // directed: mode switches every cycle, extremes, validity toggles
        drive(k, (k % 2) ? 16'h8000 : 16'h7FFF, (k != 5), 2'(k), 16'(16'h0100 + k), 1'b1);
      else if (k < 40)
        drive(k, (k % 3 == 0) ? 16'h8000 : 16'(k * 977), (k % 5 != 0),
              (k < 20) ? 2'b01 : 2'($urandom_range(0, 3)), 16'(k * 31), 1'b1);
      else if (k < 60)
        // doubled-rate entry right after other modes, long run
        drive(k, 16'(16'hA000 + k), (k % 7 != 3), (k < 45) ? 2'(k) : 2'b11,
              16'(16'h5000 + k), 1'b0);
      else
        drive(k, rnd_smp(), ($urandom_range(0, 9) < 8), 2'($urandom_range(0, 3)),
              rnd_smp(), 1'b0);
      if (k == 0) begin
        // first cycle after release: pair still from reset
        @(posedge clk);
        #1;
        // output now shows cycle 0, judged at next negedge
      end
      @(negedge clk);
    end
    check_cycle(N - 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule